// File: doc/BRIEF.md
# FSM State Equivalence Partitioner

This block takes a completely specified Mealy state table and computes the classes of equivalent states. The table can hold up to `N_STATES` states, with one input bit and one output bit. For every state, a write port stores the next state and the output for input 0 and for input 1. When `start` is pulsed, the engine first groups together the states whose outputs agree. It then refines that grouping one round at a time. In each round, two states stay together only if they shared a block before and their successors under both inputs also shared a block before. The engine stops when a round reproduces the previous partition.

Every state receives a block label. The label is the index of the lowest-numbered state in its block, so the labels are canonical and two partitions can be compared entry by entry. When the engine finishes, it reports the number of the last partition it computed and the number of classes. The labels can then be read through an address port.

A typical use is to load the table with `cfg_states` naming how many states are active, pulse `start`, wait for `done`, and read the labels. The labels map each original state onto its state in the minimal machine.

Top module: `fsm_equiv_partitioner`

## Requirements
- R1: After reset, `busy`, `done`, `rounds` and `classes` are 0, and every label reads 0.
- R2: While `busy` is low, `tbl_we` stores the following for state `tbl_addr`: `tbl_next0` and `tbl_out0` (input bit 0), and `tbl_next1` and `tbl_out1` (input bit 1).
- R3: The first partition puts two states in one block exactly when they have equal outputs for input 0 and equal outputs for input 1. A table whose outputs are all equal yields one class after 2 rounds.
- R4: Each later partition keeps states s and t together only if three conditions hold: s and t were together in the previous partition, their input-0 successors were together in it, and their input-1 successors were together in it.
- R5: Each label equals the lowest state index in its block, so state 0 always reads label 0.
- R6: The run ends when a partition equals the previous one. `rounds` then gives the index of the last partition (the first partition is 1), `classes` gives its block count, `done` rises, and `busy` falls. Example: five states, with input-0 outputs all 0; input 1 moves 0→1, 1→2, 2→3, 3→4 and 4→4, with output 1 only from states 3 and 4. The result is labels 0,1,2,3,3, rounds=4 and classes=4.
- R7: A run never exceeds n rounds for n active states. A chain in which each state moves to the next and the last state alone outputs 1 gives rounds=n and classes=n.
- R8: `start` has no effect while `busy` is high, and the state count is latched when the run starts.
- R9: `tbl_we` has no effect while `busy` is high.
- R10: If `cfg_states` is 0 or larger than `N_STATES`, the engine uses `N_STATES`. With `cfg_states`=1, the result is rounds=1 and classes=1.
- R11: `done`, `rounds`, `classes` and the labels hold until the next accepted `start`. The label of state `rd_addr` appears on `rd_label` after `RD_REG` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write enable |
| tbl_addr | input | SW | State being written |
| tbl_next0 | input | SW | Next state on input 0 |
| tbl_next1 | input | SW | Next state on input 1 |
| tbl_out0 | input | 1 | Output on input 0 |
| tbl_out1 | input | 1 | Output on input 1 |
| cfg_states | input | CW | Number of active states |
| start | input | 1 | Start pulse |
| rd_addr | input | SW | State whose label is read |
| rd_label | output | SW | Block label of `rd_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid |
| rounds | output | CW | Index of the last partition computed |
| classes | output | CW | Number of equivalence classes |

## Verification
The bench builds the block with `N_STATES`=8 and `RD_REG`=1. The eight-entry table makes the longest refinement chain reachable: eight rounds that end exactly at the cap. It also allows an out-of-range state count of 9 to be presented. The registered read variant adds one cycle of read latency, which every label check has to respect. Random tables of 3, 6 and 8 states run against an in-bench software partitioner.

// File: rtl/fsmp_pkg.sv
package fsmp_pkg;
   typedef enum logic [1:0] {
      CT_IDLE = 2'd0,
      CT_PAIR = 2'd1,
      CT_CMP  = 2'd2
   } ctl_e;
endpackage

// File: rtl/fsmp_table.sv
module fsmp_table #(
   parameter int N_STATES = 8,
   parameter int SW       = $clog2(N_STATES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [SW-1:0]                addr,
   input  logic [SW-1:0]                nx0,
   input  logic [SW-1:0]                nx1,
   input  logic                         o0,
   input  logic                         o1,
   output logic [N_STATES-1:0][SW-1:0]  nx0_q,
   output logic [N_STATES-1:0][SW-1:0]  nx1_q,
   output logic [N_STATES-1:0]          o0_q,
   output logic [N_STATES-1:0]          o1_q
);
   for (genvar k = 0; k < N_STATES; k++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nx0_q[k] <= '0;
            nx1_q[k] <= '0;
            o0_q[k]  <= 1'b0;
            o1_q[k]  <= 1'b0;
         end else if (we && (addr == SW'(k))) begin
            nx0_q[k] <= nx0;
            nx1_q[k] <= nx1;
            o0_q[k]  <= o0;
            o1_q[k]  <= o1;
         end
      end
   end
endmodule

// File: rtl/fsmp_label_bank.sv
module fsmp_label_bank #(
   parameter int N_STATES = 8,
   parameter int SW       = $clog2(N_STATES),
   parameter bit RD_REG   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [SW-1:0]                wr_idx,
   input  logic [SW-1:0]                wr_val,
   input  logic                         copy,
   input  logic [SW-1:0]                rd_addr,
   output logic [N_STATES-1:0][SW-1:0]  prev_q,
   output logic [N_STATES-1:0][SW-1:0]  cur_q,
   output logic [SW-1:0]                rd_label
);
   for (genvar k = 0; k < N_STATES; k++) begin : g_lab
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_q[k]  <= '0;
            prev_q[k] <= '0;
         end else begin
            if (wr && (wr_idx == SW'(k))) cur_q[k] <= wr_val;
            if (copy)                     prev_q[k] <= cur_q[k];
         end
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_label <= '0;
         else        rd_label <= cur_q[rd_addr];
      end
   end else begin : g_rd_comb
      assign rd_label = cur_q[rd_addr];
   end
endmodule

// File: rtl/fsmp_pair_match.sv
module fsmp_pair_match #(
   parameter int N_STATES = 8,
   parameter int SW       = $clog2(N_STATES)
) (
   input  logic                         first,
   input  logic [SW-1:0]                si,
   input  logic [SW-1:0]                sj,
   input  logic [N_STATES-1:0][SW-1:0]  nx0_q,
   input  logic [N_STATES-1:0][SW-1:0]  nx1_q,
   input  logic [N_STATES-1:0]          o0_q,
   input  logic [N_STATES-1:0]          o1_q,
   input  logic [N_STATES-1:0][SW-1:0]  prev_q,
   output logic                         match
);
   logic same_out, same_blk, same_s0, same_s1;

   always_comb begin
      same_out = (o0_q[si] == o0_q[sj]) && (o1_q[si] == o1_q[sj]);
      same_blk = (prev_q[si] == prev_q[sj]);
      same_s0  = (prev_q[nx0_q[si]] == prev_q[nx0_q[sj]]);
      same_s1  = (prev_q[nx1_q[si]] == prev_q[nx1_q[sj]]);
      match    = first ? same_out : (same_blk && same_s0 && same_s1);
   end
endmodule

// File: rtl/fsm_equiv_partitioner.sv
module fsm_equiv_partitioner #(
   parameter int N_STATES = 8,
   parameter bit RD_REG   = 1'b0,
   localparam int SW      = $clog2(N_STATES),
   localparam int CW      = $clog2(N_STATES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tbl_we,
   input  logic [SW-1:0] tbl_addr,
   input  logic [SW-1:0] tbl_next0,
   input  logic [SW-1:0] tbl_next1,
   input  logic          tbl_out0,
   input  logic          tbl_out1,
   input  logic [CW-1:0] cfg_states,
   input  logic          start,
   input  logic [SW-1:0] rd_addr,
   output logic [SW-1:0] rd_label,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] rounds,
   output logic [CW-1:0] classes
);
   import fsmp_pkg::*;

   if (N_STATES < 2 || N_STATES > 64) begin : g_bad_n
      $error("fsm_equiv_partitioner: N_STATES must lie in 2..64");
   end

   ctl_e          st;
   logic [SW-1:0] si, sj;
   logic [CW-1:0] round, n_lat, cls;
   logic          diff;
   logic [CW-1:0] eff_n;
   logic          match, lb_wr, lb_copy, last_pair, finish;

   logic [N_STATES-1:0][SW-1:0] nx0_q, nx1_q, prev_q, cur_q;
   logic [N_STATES-1:0]         o0_q, o1_q;

   fsmp_table #(.N_STATES(N_STATES), .SW(SW)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we && !busy),
      .addr  (tbl_addr),
      .nx0   (tbl_next0),
      .nx1   (tbl_next1),
      .o0    (tbl_out0),
      .o1    (tbl_out1),
      .nx0_q (nx0_q),
      .nx1_q (nx1_q),
      .o0_q  (o0_q),
      .o1_q  (o1_q)
   );

   fsmp_pair_match #(.N_STATES(N_STATES), .SW(SW)) u_match (
      .first  (round == CW'(1)),
      .si     (si),
      .sj     (sj),
      .nx0_q  (nx0_q),
      .nx1_q  (nx1_q),
      .o0_q   (o0_q),
      .o1_q   (o1_q),
      .prev_q (prev_q),
      .match  (match)
   );

   fsmp_label_bank #(.N_STATES(N_STATES), .SW(SW), .RD_REG(RD_REG)) u_labels (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (lb_wr),
      .wr_idx   (sj),
      .wr_val   (si),
      .copy     (lb_copy),
      .rd_addr  (rd_addr),
      .prev_q   (prev_q),
      .cur_q    (cur_q),
      .rd_label (rd_label)
   );

   always_comb begin
      eff_n     = ((cfg_states == '0) || (cfg_states > CW'(N_STATES))) ? CW'(N_STATES) : cfg_states;
      lb_wr     = (st == CT_PAIR) && match;
      last_pair = (CW'(sj) == (n_lat - CW'(1)));
      finish    = (round == n_lat) || ((round != CW'(1)) && !diff);
      lb_copy   = (st == CT_CMP) && !finish;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= CT_IDLE;
         si      <= '0;
         sj      <= '0;
         round   <= '0;
         n_lat   <= '0;
         cls     <= '0;
         diff    <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rounds  <= '0;
         classes <= '0;
      end else begin
         case (st)
            CT_IDLE: begin
               if (start) begin
                  n_lat <= eff_n;
                  round <= CW'(1);
                  si    <= '0;
                  sj    <= '0;
                  cls   <= '0;
                  diff  <= 1'b0;
                  busy  <= 1'b1;
                  done  <= 1'b0;
                  st    <= CT_PAIR;
               end
            end
            CT_PAIR: begin
               if (match) begin
                  if (si == sj)          cls  <= cls + CW'(1);
                  if (si != prev_q[sj])  diff <= 1'b1;
                  si <= '0;
                  if (last_pair) st <= CT_CMP;
                  else           sj <= sj + SW'(1);
               end else begin
                  si <= si + SW'(1);
               end
            end
            CT_CMP: begin
               if (finish) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rounds  <= round;
                  classes <= cls;
                  st      <= CT_IDLE;
               end else begin
                  round <= round + CW'(1);
                  cls   <= '0;
                  diff  <= 1'b0;
                  si    <= '0;
                  sj    <= '0;
                  st    <= CT_PAIR;
               end
            end
            default: st <= CT_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsmp_checker.sv
module fsmp_checker #(
   parameter int N_STATES = 8,
   parameter int SW       = 3,
   parameter int CW       = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         busy,
   input logic                         done,
   input logic [CW-1:0]                round,
   input logic [CW-1:0]                n_lat,
   input logic [CW-1:0]                classes,
   input logic [N_STATES-1:0][SW-1:0]  nx0_q,
   input logic [N_STATES-1:0][SW-1:0]  nx1_q,
   input logic [N_STATES-1:0]          o0_q,
   input logic [N_STATES-1:0]          o1_q,
   input logic [N_STATES-1:0][SW-1:0]  cur_q
);
   // R6: a finished result and a running engine never coexist
   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R6: done rises only at the end of a run
   a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R6: class count lies between 1 and the active state count
   a_r6_classes_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (classes >= CW'(1)) && (classes <= n_lat));

   // R7: the round counter never passes the cap
   a_r7_round_capped: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (round >= CW'(1)) && (round <= n_lat));

   // R8: the latched state count holds through a run
   a_r8_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(n_lat));

   // R9: the table does not change while a run is in progress
   a_r9_table_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(nx0_q) && $stable(nx1_q) && $stable(o0_q) && $stable(o1_q)));

   // R5: state 0 always heads its own block
   a_r5_state0_label: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cur_q[0] == '0));
endmodule

bind fsm_equiv_partitioner fsmp_checker #(
   .N_STATES (N_STATES),
   .SW       (SW),
   .CW       (CW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .round   (round),
   .n_lat   (n_lat),
   .classes (classes),
   .nx0_q   (nx0_q),
   .nx1_q   (nx1_q),
   .o0_q    (o0_q),
   .o1_q    (o1_q),
   .cur_q   (cur_q)
);

// File: tb/fsm_equiv_partitioner_tb.sv
`timescale 1ns/1ps
module fsm_equiv_partitioner_tb;
   localparam int N  = 8;
   localparam int SW = 3;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [SW-1:0] tbl_addr = '0, tbl_next0 = '0, tbl_next1 = '0;
   logic          tbl_out0 = 1'b0, tbl_out1 = 1'b0;
   logic [CW-1:0] cfg_states = '0;
   logic          start = 1'b0;
   logic [SW-1:0] rd_addr = '0;
   logic [SW-1:0] rd_label;
   logic          busy, done;
   logic [CW-1:0] rounds, classes;

   int total = 0;
   int bad   = 0;

   int m_n0[N], m_n1[N], m_o0[N], m_o1[N];
   int ref_lab[N];
   int ref_rounds, ref_cls;
   int exp_q[$];

   always #2.5 clk = ~clk;

   fsm_equiv_partitioner #(.N_STATES(N), .RD_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_next0(tbl_next0), .tbl_next1(tbl_next1), .tbl_out0(tbl_out0),
      .tbl_out1(tbl_out1), .cfg_states(cfg_states), .start(start),
      .rd_addr(rd_addr), .rd_label(rd_label), .busy(busy), .done(done),
      .rounds(rounds), .classes(classes)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_entry(input int s, input int n0, input int n1, input int o0, input int o1);
      tbl_we = 1'b1; tbl_addr = SW'(s);
      tbl_next0 = SW'(n0); tbl_next1 = SW'(n1);
      tbl_out0 = o0[0]; tbl_out1 = o1[0];
      if (!busy) begin m_n0[s] = n0; m_n1[s] = n1; m_o0[s] = o0; m_o1[s] = o1; end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic pulse_start(input int n);
      cfg_states = CW'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int c = 0; c < 5000; c++) begin
         if (done) return;
         @(negedge clk);
      end
      check("R6 done timeout", 0, 1);
   endtask

   task automatic read_label(input int a, output int v);
      rd_addr = SW'(a);
      @(posedge clk);
      @(negedge clk);
      v = int'(rd_label);
   endtask

   // software partitioner from the requirements
   task automatic ref_model(input int n);
      int prv[N];
      int nw[N];
      bool_loop: begin end
      for (int j = 0; j < n; j++)
         for (int i = 0; i <= j; i++)
            if (m_o0[i] == m_o0[j] && m_o1[i] == m_o1[j]) begin nw[j] = i; break; end
      ref_rounds = 1;
      while (ref_rounds < n) begin
         bit same;
         for (int k = 0; k < n; k++) prv[k] = nw[k];
         ref_rounds++;
         for (int j = 0; j < n; j++)
            for (int i = 0; i <= j; i++)
               if (prv[i] == prv[j] && prv[m_n0[i]] == prv[m_n0[j]] && prv[m_n1[i]] == prv[m_n1[j]]) begin
                  nw[j] = i; break;
               end
         same = 1'b1;
         for (int k = 0; k < n; k++) if (nw[k] != prv[k]) same = 1'b0;
         if (same) break;
      end
      ref_cls = 0;
      for (int k = 0; k < n; k++) begin
         ref_lab[k] = nw[k];
         if (nw[k] == k) ref_cls++;
      end
   endtask

   // driver side: queue expected labels from the model
   task automatic push_expected(input int n);
      ref_model(n);
      for (int k = 0; k < n; k++) exp_q.push_back(ref_lab[k]);
   endtask

   // monitor side: pop and compare against read labels
   task automatic drain_labels(input string tag);
      int k = 0;
      while (exp_q.size() > 0) begin
         int e, v;
         e = exp_q.pop_front();
         read_label(k, v);
         check($sformatf("%s label[%0d]", tag, k), v, e);
         k++;
      end
   endtask

   task automatic run_and_score(input string tag, input int n);
      pulse_start(n);
      wait_done();
      push_expected(n);
      check({tag, " rounds"}, int'(rounds), ref_rounds);
      check({tag, " classes"}, int'(classes), ref_cls);
      drain_labels(tag);
   endtask

   task automatic load_example5();
      write_entry(0, 0, 1, 0, 0);
      write_entry(1, 0, 2, 0, 0);
      write_entry(2, 0, 3, 0, 0);
      write_entry(3, 0, 4, 0, 1);
      write_entry(4, 0, 4, 0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 rounds", rounds, 0);
      check("R1 classes", classes, 0);
      for (int k = 0; k < N; k++) begin
         read_label(k, v);
         check("R1 label", v, 0);
      end

      // R2 R6 worked example with fixed expectations
      load_example5();
      pulse_start(5);
      wait_done();
      check("R6 busy low", busy, 0);
      check("R6 rounds", rounds, 4);
      check("R6 classes", classes, 4);
      exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
      exp_q.push_back(3); exp_q.push_back(3);
      drain_labels("R6 R2 R5");

      // R11 result holds while idle
      repeat (10) @(negedge clk);
      check("R11 done held", done, 1);
      check("R11 rounds held", rounds, 4);

      // R8 start ignored while busy
      pulse_start(5);
      check("R8 busy", busy, 1);
      check("R11 done cleared", done, 0);
      repeat (3) @(negedge clk);
      pulse_start(1);
      // R9 write ignored while busy
      write_entry(3, 0, 4, 0, 0);
      wait_done();
      check("R8 rounds", rounds, 4);
      check("R8 classes", classes, 4);
      pulse_start(5);
      wait_done();
      check("R9 classes after rerun", classes, 4);
      read_label(4, v);
      check("R9 label[4]", v, 3);

      // R3 all outputs equal
      for (int k = 0; k < N; k++) write_entry(k, (k + 3) % N, (k * 5 + 1) % N, 0, 0);
      pulse_start(8);
      wait_done();
      check("R3 rounds", rounds, 2);
      check("R3 classes", classes, 1);
      for (int k = 0; k < N; k++) exp_q.push_back(0);
      drain_labels("R3 R5");

      // R7 chain reaches the cap
      for (int k = 0; k < N; k++)
         write_entry(k, (k < N-1) ? k+1 : k, (k < N-1) ? k+1 : k, (k == N-1), (k == N-1));
      pulse_start(8);
      wait_done();
      check("R7 rounds", rounds, 8);
      check("R7 classes", classes, 8);
      for (int k = 0; k < N; k++) exp_q.push_back(k);
      drain_labels("R7");

      // R10 out-of-range and single-state counts
      pulse_start(0);
      wait_done();
      check("R10 count 0 rounds", rounds, 8);
      pulse_start(9);
      wait_done();
      check("R10 count 9 classes", classes, 8);
      pulse_start(1);
      wait_done();
      check("R10 count 1 rounds", rounds, 1);
      check("R10 count 1 classes", classes, 1);
      read_label(0, v);
      check("R10 label[0]", v, 0);

      // R4 random tables against the model
      void'($urandom(32'h5eed));
      for (int t = 0; t < 9; t++) begin
         int n;
         n = (t % 3 == 0) ? 3 : ((t % 3 == 1) ? 6 : 8);
         for (int k = 0; k < n; k++)
            write_entry(k, $urandom % n, $urandom % n, $urandom % 2, (t > 4) ? 0 : $urandom % 2);
         run_and_score($sformatf("R4 rand%0d", t), n);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule